// File: doc/BRIEF.md
# Infrared Link Buffer Service Controller

This block is the buffering and service-request core of a medium or fast infrared serial link. A transmit byte FIFO feeds a serial output shifter, and a receive framer assembles serial bits into bytes that land in a receive FIFO. Each direction has its own enable bit. Clearing that bit halts the direction at once and discards everything it holds. The two directions never wait on each other, so a loop-back path or full-duplex traffic works without restriction.

Each FIFO drives a service flag from its fill level. The flag feeds a DMA request directly, and it feeds an interrupt request through a mask bit. On receive, the framer looks at the first byte after each frame start. It keeps the frame or drops it based on an 8-bit match value and the all-ones broadcast address. A frame's end or abort places a marker entry in the receive FIFO and raises a sticky end/error flag. That flag holds off receive DMA until software clears it.

Software reaches the block through a synchronous register port. A write strobe with address and 32-bit data sets control or pushes a transmit byte. A read strobe on the data address pops the receive FIFO.

Top module: `ir_buf_svc`

## Requirements
- R1: While the transmit enable (control bit 0) is low, the transmit FIFO and output shifter are emptied, data writes are ignored, and the serial output idles at 1.
- R2: While the receive enable (control bit 1) is low, the receive FIFO is emptied and the framer discards any partial byte and frame state, so bits received before a disable never appear after re-enable.
- R3: Transmit and receive operate at the same time without interference. A push and a pop that reach one FIFO in the same cycle leave its count unchanged.
- R4: The receive interrupt is high exactly when the receive service flag is set and the receive mask (control bit 3) is 1. The mask has no effect on the flag.
- R5: The receive DMA request is high when the receive service flag is set and the end/error flag is clear, whatever the mask holds.
- R6: The transmit interrupt is the transmit service flag ANDed with the transmit mask (control bit 2). The transmit DMA request equals the transmit service flag.
- R7: With address matching on (control bit 4), a frame is stored only if its first byte equals the match value (control bits 15:8) or 0xFF. Otherwise the frame leaves the FIFO and the flags unchanged.
- R8: With address matching off, every frame is stored, including its address byte.
- R9: With the default 16-entry depth, the transmit service flag is set while transmit is enabled and the transmit FIFO holds 8 or fewer bytes. The receive service flag is set while the receive FIFO holds 8 or more entries.
- R10: Ending a stored frame with the end strobe pushes the marker entry 0x100; ending it with the error strobe pushes 0x101. Either push sets the end/error flag (status bit 2), which stays set until a write of 1 to status bit 2.
- R11: The keep-or-drop decision is made on the first complete byte after frame start and holds until the frame ends. The address byte of a kept frame is stored as the first entry.
- R12: Register map: address 0 is control, 1 is status, and 2 is data. Status bit 0 is the transmit flag and bit 1 the receive flag. Status bits 12:8 hold the transmit count and bits 20:16 the receive count. A data read returns the head byte in bits 7:0, the marker bit in bit 8 and not-empty in bit 9. Serial bits move LSB first, one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive FIFO at data address) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_tick | input | 1 | Transmit bit strobe from modulator |
| tx_bit | output | 1 | Serial transmit bit, idle 1 |
| rx_tick | input | 1 | Receive bit strobe from demodulator |
| rx_bit | input | 1 | Serial receive bit |
| rx_sof | input | 1 | Frame start strobe |
| rx_eof | input | 1 | Frame end strobe |
| rx_err | input | 1 | Frame abort/error strobe |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The receive FIFO can take a byte from the framer and lose its head to a software read in the same cycle. The bench provokes this by aligning the eighth bit tick of a byte with a data-register read, on a FIFO that already holds nine entries. It then checks that the status count stays at nine. A second overlap runs the transmit shifter and the receive framer on the same ticks. The bench judges that by both counts moving exactly as each direction would move on its own.

// File: rtl/ir_svc_pkg.sv
package ir_svc_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int STA_EOF_BIT = 2;

    localparam logic [7:0] ADDR_BCAST = 8'hFF;
    localparam logic [7:0] MARK_END   = 8'h00;
    localparam logic [7:0] MARK_ERR   = 8'h01;

    typedef struct packed {
        logic [7:0] match;
        logic       am_en;
        logic       rx_im;
        logic       tx_im;
        logic       rx_en;
        logic       tx_en;
    } ctrl_t;

endpackage

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_FULL) || do_pop);
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = wdata;
                st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_FULL);

    // R3
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !flush) |=> (count == $past(count)));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/ir_tx_shifter.sv
module ir_tx_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       avail,
    input  logic [7:0] din,
    output logic       take,
    output logic       ser_o,
    output logic       busy_o
);
    typedef struct packed {
        logic       busy;
        logic [7:0] sh;
        logic [2:0] nb;
    } tx_st_t;

    tx_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            if (st_q.busy && (st_q.nb != 3'd7)) begin
                st_d.sh = {1'b1, st_q.sh[7:1]};
                st_d.nb = st_q.nb + 1'b1;
            end else if (avail) begin
                st_d.busy = 1'b1;
                st_d.sh   = din;
                st_d.nb   = 3'd0;
                take      = 1'b1;
            end else begin
                st_d.busy = 1'b0;
                st_d.nb   = 3'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_o  = st_q.busy ? st_q.sh[0] : 1'b1;
    assign busy_o = st_q.busy;

    // R1
    tx_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy_o && ser_o));

endmodule

// File: rtl/ir_rx_framer.sv
module ir_rx_framer
    import ir_svc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       ser_i,
    input  logic       sof,
    input  logic       eof,
    input  logic       err,
    input  logic       am_en,
    input  logic [7:0] match,
    output logic       push,
    output logic [8:0] pdata
);
    typedef struct packed {
        logic       in_frame;
        logic       have_addr;
        logic       keep;
        logic [7:0] sh;
        logic [2:0] nb;
    } rx_st_t;

    rx_st_t     st_q, st_d;
    logic [7:0] nxt_byte;
    logic       hit;

    always_comb begin
        st_d     = st_q;
        push     = 1'b0;
        pdata    = '0;
        nxt_byte = {ser_i, st_q.sh[7:1]};
        hit      = !am_en || (nxt_byte == match) || (nxt_byte == ADDR_BCAST);
        if (!en) begin
            st_d = '0;
        end else if (sof) begin
            st_d.in_frame  = 1'b1;
            st_d.have_addr = 1'b0;
            st_d.keep      = 1'b0;
            st_d.nb        = 3'd0;
        end else if ((eof || err) && st_q.in_frame) begin
            push          = st_q.keep;
            pdata         = {1'b1, (err ? MARK_ERR : MARK_END)};
            st_d.in_frame = 1'b0;
            st_d.nb       = 3'd0;
        end else if (tick && st_q.in_frame) begin
            st_d.sh = nxt_byte;
            if (st_q.nb == 3'd7) begin
                st_d.nb = 3'd0;
                pdata   = {1'b0, nxt_byte};
                if (!st_q.have_addr) begin
                    st_d.have_addr = 1'b1;
                    st_d.keep      = hit;
                    push           = hit;
                end else begin
                    push = st_q.keep;
                end
            end else begin
                st_d.nb = st_q.nb + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    keep_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.in_frame && st_q.have_addr && !sof) |=> (st_q.keep == $past(st_q.keep)));

    // R2
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!st_q.in_frame && (st_q.nb == 3'd0)));

endmodule

// File: rtl/ir_buf_svc.sv
module ir_buf_svc
    import ir_svc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TX_LOW  = 8,
    parameter int RX_HIGH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_tick,
    output logic        tx_bit,
    input  logic        rx_tick,
    input  logic        rx_bit,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_err,
    output logic        tx_irq,
    output logic        rx_irq,
    output logic        tx_dma_req,
    output logic        rx_dma_req
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] TX_LOW_C  = CW'(TX_LOW);
    localparam logic [CW-1:0] RX_HIGH_C = CW'(RX_HIGH);

    typedef struct packed {
        ctrl_t ctrl;
        logic  eof;
    } top_st_t;

    top_st_t       st_q, st_d;
    logic          tx_push, tx_take, tx_empty, tx_full, tx_busy;
    logic [7:0]    tx_head;
    logic [CW-1:0] tx_cnt;
    logic          rx_req, rx_pop, rx_empty, rx_full, rx_set;
    logic [8:0]    rx_pdata, rx_head;
    logic [CW-1:0] rx_cnt;
    logic          tx_svc, rx_svc;

    assign tx_push = reg_we && (reg_addr == REG_DATA) && st_q.ctrl.tx_en;
    assign rx_pop  = reg_re && (reg_addr == REG_DATA);
    assign rx_set  = rx_req && rx_pdata[8] && (!rx_full || rx_pop);

    always_comb begin
        st_d = st_q;
        if (reg_we && (reg_addr == REG_CTRL)) begin
            st_d.ctrl.tx_en = reg_wdata[0];
            st_d.ctrl.rx_en = reg_wdata[1];
            st_d.ctrl.tx_im = reg_wdata[2];
            st_d.ctrl.rx_im = reg_wdata[3];
            st_d.ctrl.am_en = reg_wdata[4];
            st_d.ctrl.match = reg_wdata[15:8];
        end
        if (rx_set)
            st_d.eof = 1'b1;
        else if (reg_we && (reg_addr == REG_STAT) && reg_wdata[STA_EOF_BIT])
            st_d.eof = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ir_byte_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!st_q.ctrl.tx_en),
        .push(tx_push), .wdata(reg_wdata[7:0]), .pop(tx_take),
        .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    ir_tx_shifter u_tx_sh (
        .clk(clk), .rst_n(rst_n), .en(st_q.ctrl.tx_en), .tick(tx_tick),
        .avail(!tx_empty), .din(tx_head), .take(tx_take),
        .ser_o(tx_bit), .busy_o(tx_busy)
    );

    ir_rx_framer u_rx_fr (
        .clk(clk), .rst_n(rst_n), .en(st_q.ctrl.rx_en), .tick(rx_tick),
        .ser_i(rx_bit), .sof(rx_sof), .eof(rx_eof), .err(rx_err),
        .am_en(st_q.ctrl.am_en), .match(st_q.ctrl.match),
        .push(rx_req), .pdata(rx_pdata)
    );

    ir_byte_fifo #(.W(9), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!st_q.ctrl.rx_en),
        .push(rx_req), .wdata(rx_pdata), .pop(rx_pop),
        .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    assign tx_svc     = st_q.ctrl.tx_en && (tx_cnt <= TX_LOW_C);
    assign rx_svc     = (rx_cnt >= RX_HIGH_C);
    assign tx_irq     = tx_svc && st_q.ctrl.tx_im;
    assign tx_dma_req = tx_svc;
    assign rx_irq     = rx_svc && st_q.ctrl.rx_im;
    assign rx_dma_req = rx_svc && !st_q.eof;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[15:8] = st_q.ctrl.match;
                reg_rdata[4:0]  = {st_q.ctrl.am_en, st_q.ctrl.rx_im, st_q.ctrl.tx_im,
                                   st_q.ctrl.rx_en, st_q.ctrl.tx_en};
            end
            REG_STAT: begin
                reg_rdata[0]           = tx_svc;
                reg_rdata[1]           = rx_svc;
                reg_rdata[STA_EOF_BIT] = st_q.eof;
                reg_rdata[8 +: CW]     = tx_cnt;
                reg_rdata[16 +: CW]    = rx_cnt;
            end
            REG_DATA: begin
                reg_rdata[8:0] = rx_head;
                reg_rdata[9]   = !rx_empty;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R1
    tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.tx_en |=> (tx_cnt == '0));

    // R2
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.rx_en |=> (rx_cnt == '0));

    // R5
    rx_dma_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (rx_cnt >= RX_HIGH_C));

    // R6
    tx_dma_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (st_q.ctrl.tx_en && (tx_cnt <= TX_LOW_C)));

    // R10
    eof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.eof) |-> $past(rx_req && rx_pdata[8]));

endmodule

// File: tb/ir_buf_svc_tb.sv
module ir_buf_svc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_tick = 1'b0, tx_bit;
    logic        rx_tick = 1'b0, rx_bit = 1'b0;
    logic        rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic        tx_irq, rx_irq, tx_dma_req, rx_dma_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

    // {addr-match enable, match value, frame address, expected keep}
    localparam logic [17:0] VEC [5] = '{
        {1'b0, 8'h12, 8'h34, 1'b1},
        {1'b1, 8'h12, 8'h12, 1'b1},
        {1'b1, 8'h12, 8'h34, 1'b0},
        {1'b1, 8'h12, 8'hFF, 1'b1},
        {1'b1, 8'h55, 8'h54, 1'b0}
    };

    always #2 clk = ~clk;

    ir_buf_svc u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_tick(tx_tick), .tx_bit(tx_bit), .rx_tick(rx_tick), .rx_bit(rx_bit),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, bit pop, output logic [31:0] v);
        reg_addr = a; reg_re = pop;
        #1 v = reg_rdata;
        step(1);
        reg_re = 1'b0;
    endtask

    task automatic rxbyte(logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            rx_bit = b[i]; rx_tick = 1'b1;
            step(1);
        end
        rx_tick = 1'b0;
    endtask

    task automatic sof();
        rx_sof = 1'b1; step(1); rx_sof = 1'b0;
    endtask

    task automatic eof(bit e);
        if (e) rx_err = 1'b1; else rx_eof = 1'b1;
        step(1);
        rx_err = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic txtick();
        tx_tick = 1'b1; step(1); tx_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R12 reset state
        rd(A_STAT, 0, v);
        check("R12 reset status", v, 32'h0);
        check("R1 reset idle", {28'h0, tx_bit, tx_irq, tx_dma_req, rx_irq | rx_dma_req}, 32'h8);

        // R7 R8 R11 address filter table
        for (int i = 0; i < 5; i++) begin
            logic       ame, kp;
            logic [7:0] mv, ad;
            ame = VEC[i][17]; mv = VEC[i][16:9]; ad = VEC[i][8:1]; kp = VEC[i][0];
            wr(A_CTRL, {16'h0, mv, 3'b000, ame, 4'b0010});
            wr(A_STAT, 32'h4);
            sof();
            rxbyte(ad);
            rxbyte(8'hA5);
            eof(1'b0);
            rd(A_STAT, 0, v);
            check(ame ? "R7 filter status" : "R8 store all status", v, kp ? 32'h0003_0004 : 32'h0);
            if (kp) begin
                rd(A_DATA, 1, v);
                check("R11 address byte first", v, {22'h0, 2'b10, ad});
            end
            wr(A_CTRL, 32'h0);
            step(1);
            rd(A_STAT, 0, v);
            check("R2 flush after disable", v[20:16], 32'h0 | (kp ? 32'h0 : 32'h0));
            wr(A_STAT, 32'h4);
        end

        // R2 partial byte discarded across disable
        wr(A_CTRL, 32'h2);
        sof();
        for (int i = 0; i < 4; i++) begin rx_bit = 1'b1; rx_tick = 1'b1; step(1); end
        rx_tick = 1'b0;
        wr(A_CTRL, 32'h0);
        step(1);
        wr(A_CTRL, 32'h2);
        sof();
        rxbyte(8'h3C);
        eof(1'b0);
        rd(A_DATA, 1, v);
        check("R2 clean byte after re-enable", v, 32'h0000_023C);
        rd(A_DATA, 1, v);
        check("R10 end marker", v, 32'h0000_0300);
        rd(A_STAT, 0, v);
        check("R10 flag set", v, 32'h4);
        wr(A_STAT, 32'h4);
        rd(A_STAT, 0, v);
        check("R10 flag cleared", v, 32'h0);
        sof();
        rxbyte(8'h77);
        eof(1'b1);
        rd(A_DATA, 1, v);
        check("R10 data before error", v, 32'h0000_0277);
        rd(A_DATA, 1, v);
        check("R10 error marker", v, 32'h0000_0301);
        wr(A_STAT, 32'h4);

        // R4 R5 R9 receive thresholds and requests
        sof();
        for (int i = 0; i < 7; i++) rxbyte(8'(i + 1));
        rd(A_STAT, 0, v);
        check("R9 rx below threshold", v, 32'h0007_0000);
        rxbyte(8'h08);
        rd(A_STAT, 0, v);
        check("R9 rx at threshold", v, 32'h0008_0002);
        check("R4 masked rx irq", {31'h0, rx_irq}, 32'h0);
        check("R5 rx dma unmasked", {31'h0, rx_dma_req}, 32'h1);
        wr(A_CTRL, 32'hA);
        check("R4 rx irq enabled", {31'h0, rx_irq}, 32'h1);
        eof(1'b0);
        check("R5 dma held by flag", {31'h0, rx_dma_req}, 32'h0);
        check("R4 irq unaffected by flag", {31'h0, rx_irq}, 32'h1);
        wr(A_STAT, 32'h4);
        check("R5 dma after clear", {31'h0, rx_dma_req}, 32'h1);

        // R3 same-cycle push and pop on receive FIFO
        sof();
        for (int i = 0; i < 7; i++) begin rx_bit = 1'b0; rx_tick = 1'b1; step(1); end
        rx_bit = 1'b1; rx_tick = 1'b1; reg_addr = A_DATA; reg_re = 1'b1;
        step(1);
        rx_tick = 1'b0; reg_re = 1'b0;
        rd(A_STAT, 0, v);
        check("R3 push+pop count", v[20:16], 32'h9);
        wr(A_CTRL, 32'h0);
        step(1);

        // R1 writes ignored while disabled
        wr(A_DATA, 32'h11);
        rd(A_STAT, 0, v);
        check("R1 push ignored disabled", v, 32'h0);

        // R6 R9 R12 transmit side
        wr(A_CTRL, 32'h1);
        check("R6 tx dma at empty", {30'h0, tx_dma_req, tx_irq}, 32'h2);
        wr(A_DATA, 32'hB4);
        for (int i = 1; i < 8; i++) wr(A_DATA, 32'(i));
        rd(A_STAT, 0, v);
        check("R9 tx at 8 bytes", v, 32'h0000_0801);
        wr(A_DATA, 32'h08);
        rd(A_STAT, 0, v);
        check("R9 tx at 9 bytes", v, 32'h0000_0900);
        wr(A_CTRL, 32'h5);
        check("R6 tx no request above level", {30'h0, tx_dma_req, tx_irq}, 32'h0);
        txtick();
        check("R6 tx irq and dma", {30'h0, tx_dma_req, tx_irq}, 32'h3);
        check("R12 first bit LSB", {31'h0, tx_bit}, 32'h0);
        txtick();
        txtick();
        check("R12 third bit", {31'h0, tx_bit}, 32'h1);

        // R3 both directions on the same ticks
        wr(A_CTRL, 32'h7);
        sof();
        for (int i = 0; i < 8; i++) begin
            rx_bit = 8'h5A >> i; rx_tick = 1'b1; tx_tick = 1'b1;
            step(1);
        end
        rx_tick = 1'b0; tx_tick = 1'b0;
        rd(A_STAT, 0, v);
        check("R3 full duplex counts", v, 32'h0001_0701);

        // R1 disable mid-transmit
        wr(A_CTRL, 32'h0);
        step(1);
        rd(A_STAT, 0, v);
        check("R1 tx flushed", v, 32'h0);
        check("R1 tx idle", {31'h0, tx_bit}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule